// File: doc/BRIEF.md
# GPIO Pin Controller with Interrupt Detection

This block manages a small array of general-purpose pins. Each pin has five registers behind a simple write-strobe and combinational-read bus: pad control, output/input data, interrupt configuration, interrupt status and interrupt destination. The controller drives each pad's output value and output enable. It forwards the pull and drive-strength codes to the pad, and a nonzero function code hands the pad over to an alternate function.

Each pad input passes through a two-flop synchronizer before it is used. Per-pin detection logic watches for a level or an edge, as the configuration asks. A hit sets a sticky status bit, which software clears by writing the status register. A parameter picks the write value that clears it. A second parameter picks the width of the detection field. The 2-bit variant encodes level, rising, falling and both edges. The 1-bit variant has only edge or level, with the sense taken from the polarity bit. A single summary interrupt collects every pin whose status is set, whose enable is on and whose destination code selects the application processor.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, `pad_oe` and `pad_out` are low, and `irq_apps` is low.
- R2: The bus address is {pin index, register select[2:0]}. Select 0 is pad control: bits [2:0] function code, [4:3] pull code (0 none, 1 pull-down, 2 keeper, 3 pull-up), [7:5] drive code n meaning (n+1)*2 mA, and [8] output enable. It reads back as written, and bits above 8 read zero.
- R3: With function code 0, a pad's `pad_out`/`pad_oe` come from data bit 0 and control bit 8. With a nonzero code they come from `alt_out`/`alt_oe`. `pad_pull`/`pad_drive` always carry the pull and drive codes.
- R4: Select 1 is data: bit 0 is the output value, and bit 1 is the synchronized pad input, which is read-only. A pad change made just after a rising edge shows in bit 1 during the third clock period that follows.
- R5: Select 2 is interrupt configuration: bit 0 enable, bit 1 polarity, [3:2] detection mode, bit 4 raw-status enable. In the 2-bit variant, mode 0 is level (polarity 1 high, 0 low), mode 1 is rising, mode 2 is falling and mode 3 is both edges. A pad edge made just after a rising edge shows in status during the fourth clock period that follows.
- R6: In the 1-bit variant, only bit 2 of the mode is stored and bit 3 reads zero. Bit 2 = 1 selects edge detection (polarity 1 rising, 0 falling), and bit 2 = 0 selects level detection (polarity 1 high, 0 low).
- R7: While raw-status enable is clear, status cannot become set.
- R8: Select 3 bit 0 is the status. It stays set until acknowledged, even if further edges arrive. In level mode it sets again right after an acknowledge while the level is still active.
- R9: Writing select 3 with bit 0 equal to the clear value (1 when ACK_CLEAR_ONE is 1, else 0) clears status. Any other write leaves it unchanged, and software cannot set it.
- R10: Select 4 bits [2:0] hold the destination. `irq_apps` is the OR over pins of status AND enable AND destination equal to 4.
- R11: Status latches while enable is clear; enable only gates the summary output.
- R12: Selects 5 to 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | {pin index, register select} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | NUM_PINS | Asynchronous pad inputs |
| alt_out | input | NUM_PINS | Alternate-function output values |
| alt_oe | input | NUM_PINS | Alternate-function output enables |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_pull | output | 2*NUM_PINS | Pull code per pin |
| pad_drive | output | 3*NUM_PINS | Drive code per pin |
| irq_apps | output | 1 | Summary interrupt to the application processor |

## Verification
The bench builds two instances side by side. One has four pins, a 2-bit detection field and clear-by-one acknowledge. It exercises all four 2-bit modes, both level senses, the raw-enable gate, destination routing and the alternate-function mux. The other has two pins, a 1-bit field and clear-by-zero acknowledge. It shows that the upper mode bit is dropped, that polarity picks the edge direction and that a write of 1 no longer acknowledges.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_SEL_W = 3;
  localparam int FUNC_W    = 3;
  localparam int PULL_W    = 2;
  localparam int DRV_W     = 3;
  localparam int DEST_W    = 3;
  localparam logic [DEST_W-1:0] DEST_APPS = 3'd4;

  typedef enum logic [REG_SEL_W-1:0] {
    REG_CTL   = 3'd0,
    REG_IO    = 3'd1,
    REG_ICFG  = 3'd2,
    REG_ISTAT = 3'd3,
    REG_ITGT  = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic              oe;
    logic [DRV_W-1:0]  drv;
    logic [PULL_W-1:0] pull;
    logic [FUNC_W-1:0] func;
  } ctl_t;

  typedef struct packed {
    logic       raw;
    logic [1:0] det;
    logic       pol;
    logic       en;
  } icfg_t;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int DET_WIDTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_s,
  input  logic [1:0] det,
  input  logic       pol,
  input  logic       raw_en,
  output logic       hit
);
  logic prev_q;
  logic rise, fall, lvl, cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= in_s;
  end

  assign rise = in_s & ~prev_q;
  assign fall = ~in_s & prev_q;
  assign lvl  = pol ? in_s : ~in_s;

  generate
    if (DET_WIDTH == 1) begin : g_w1
      always_comb begin
        if (det[0]) cond = pol ? rise : fall;
        else        cond = lvl;
      end
    end else begin : g_w2
      always_comb begin
        case (det)
          2'd1:    cond = rise;
          2'd2:    cond = fall;
          2'd3:    cond = rise | fall;
          default: cond = lvl;
        endcase
      end
    end
  endgenerate

  assign hit = raw_en & cond;
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_irq_pkg::*;
#(
  parameter int   DET_WIDTH   = 2,
  parameter logic ACK_CLR_VAL = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_SEL_W-1:0] reg_sel,
  input  logic [31:0]          wdata,
  input  logic                 pad_in_s,
  input  logic                 alt_out,
  input  logic                 alt_oe,
  output logic [31:0]          rdata,
  output logic                 pad_out,
  output logic                 pad_oe,
  output logic [PULL_W-1:0]    pad_pull,
  output logic [DRV_W-1:0]     pad_drive,
  output logic                 irq_req
);
  localparam logic [4:0] ICFG_MASK = (DET_WIDTH == 1) ? 5'b1_0111 : 5'b1_1111;

  ctl_t              ctl_q, ctl_d;
  icfg_t             icfg_q, icfg_d;
  logic              out_q, out_d;
  logic              stat_q, stat_d;
  logic [DEST_W-1:0] tgt_q, tgt_d;
  logic              wr_ctl, wr_io, wr_icfg, wr_stat, wr_tgt;
  logic              ack_clr, hit;

  assign wr_ctl  = wr_en && (reg_sel == REG_CTL);
  assign wr_io   = wr_en && (reg_sel == REG_IO);
  assign wr_icfg = wr_en && (reg_sel == REG_ICFG);
  assign wr_stat = wr_en && (reg_sel == REG_ISTAT);
  assign wr_tgt  = wr_en && (reg_sel == REG_ITGT);
  assign ack_clr = wr_stat && (wdata[0] == ACK_CLR_VAL);

  gpio_irq_detect #(.DET_WIDTH(DET_WIDTH)) u_det (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_s   (pad_in_s),
    .det    (icfg_q.det),
    .pol    (icfg_q.pol),
    .raw_en (icfg_q.raw),
    .hit    (hit)
  );

  always_comb begin
    ctl_d  = ctl_t'(wdata[$bits(ctl_t)-1:0]);
    out_d  = wdata[0];
    icfg_d = icfg_t'(wdata[4:0] & ICFG_MASK);
    tgt_d  = wdata[DEST_W-1:0];
    stat_d = hit | (stat_q & ~ack_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      out_q  <= 1'b0;
      icfg_q <= '0;
      tgt_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      if (wr_ctl)  ctl_q  <= ctl_d;
      if (wr_io)   out_q  <= out_d;
      if (wr_icfg) icfg_q <= icfg_d;
      if (wr_tgt)  tgt_q  <= tgt_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    case (reg_sel)
      REG_CTL:   rdata = 32'(ctl_q);
      REG_IO:    rdata = {30'b0, pad_in_s, out_q};
      REG_ICFG:  rdata = 32'(icfg_q);
      REG_ISTAT: rdata = {31'b0, stat_q};
      REG_ITGT:  rdata = 32'(tgt_q);
      default:   rdata = '0;
    endcase
  end

  assign pad_out   = (ctl_q.func == '0) ? out_q : alt_out;
  assign pad_oe    = (ctl_q.func == '0) ? ctl_q.oe : alt_oe;
  assign pad_pull  = ctl_q.pull;
  assign pad_drive = ctl_q.drv;
  assign irq_req   = stat_q & icfg_q.en & (tgt_q == DEST_APPS);

  // R8: a set status survives every cycle without a clearing acknowledge
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !ack_clr) |=> stat_q);

  // R9: a status write with the non-clearing value leaves status set
  assert_wrong_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && wr_stat && (wdata[0] != ACK_CLR_VAL)) |=> stat_q);

  // R7: with raw enable clear, a clear status stays clear
  assert_raw_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!icfg_q.raw && !stat_q) |=> !stat_q);

  // R5: a rising synchronized input in rising-edge mode sets status
  assert_rise_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (icfg_q.raw && icfg_q.det == 2'd1 && icfg_q.pol && pad_in_s && !$past(pad_in_s))
    |=> stat_q);

  // R5: an active high level in level mode sets status
  assert_level_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (icfg_q.raw && icfg_q.det == 2'd0 && icfg_q.pol && pad_in_s) |=> stat_q);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS      = 4,
  parameter int DET_WIDTH     = 2,
  parameter int ACK_CLEAR_ONE = 1,
  localparam int PIN_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int ADDR_W = PIN_W + REG_SEL_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  input  logic [NUM_PINS-1:0]        pad_in,
  input  logic [NUM_PINS-1:0]        alt_out,
  input  logic [NUM_PINS-1:0]        alt_oe,
  output logic [NUM_PINS-1:0]        pad_out,
  output logic [NUM_PINS-1:0]        pad_oe,
  output logic [PULL_W*NUM_PINS-1:0] pad_pull,
  output logic [DRV_W*NUM_PINS-1:0]  pad_drive,
  output logic                       irq_apps
);
  localparam logic ACK_CLR_VAL = (ACK_CLEAR_ONE != 0);

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic [NUM_PINS-1:0]  pad_in_s;
  logic [NUM_PINS-1:0]  irq_req;
  logic [31:0]          cell_rdata [NUM_PINS];
  logic [PIN_W-1:0]     pin_idx;
  logic [REG_SEL_W-1:0] reg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign pin_idx = bus_addr[ADDR_W-1:REG_SEL_W];
  assign reg_sel = bus_addr[REG_SEL_W-1:0];

  gpio_sync2 #(.W(NUM_PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (pad_in),
    .q     (pad_in_s)
  );

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      gpio_pin_cell #(.DET_WIDTH(DET_WIDTH), .ACK_CLR_VAL(ACK_CLR_VAL)) u_cell (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .wr_en     (bus_we && (pin_idx == PIN_W'(i))),
        .reg_sel   (reg_sel),
        .wdata     (bus_wdata),
        .pad_in_s  (pad_in_s[i]),
        .alt_out   (alt_out[i]),
        .alt_oe    (alt_oe[i]),
        .rdata     (cell_rdata[i]),
        .pad_out   (pad_out[i]),
        .pad_oe    (pad_oe[i]),
        .pad_pull  (pad_pull[i*PULL_W +: PULL_W]),
        .pad_drive (pad_drive[i*DRV_W +: DRV_W]),
        .irq_req   (irq_req[i])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (pin_idx == PIN_W'(i)) bus_rdata = cell_rdata[i];
    end
  end

  assign irq_apps = |irq_req;

  // R10: without any register write the summary interrupt cannot drop
  assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_apps && !bus_we) |=> irq_apps);

  // R1: summary interrupt is low while the internal reset is held
  always_comb begin
    if (!rst_int_n) assert_irq_reset_R1: assert (irq_apps == 1'b0);
  end
endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        we0, we1;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] rdata0, rdata1;
  logic [3:0]  pad_in0, alt_out0, alt_oe0, pad_out0, pad_oe0;
  logic [7:0]  pad_pull0;
  logic [11:0] pad_drive0;
  logic        irq0, irq1;
  logic [1:0]  pad_in1, pad_out1, pad_oe1;
  logic [3:0]  pad_pull1;
  logic [5:0]  pad_drive1;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  bit mon_go = 0;

  logic [31:0] exp_q[$];
  int          kind_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(4), .DET_WIDTH(2), .ACK_CLEAR_ONE(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(we0), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata0), .pad_in(pad_in0),
    .alt_out(alt_out0), .alt_oe(alt_oe0), .pad_out(pad_out0), .pad_oe(pad_oe0),
    .pad_pull(pad_pull0), .pad_drive(pad_drive0), .irq_apps(irq0)
  );

  gpio_irq_ctrl #(.NUM_PINS(2), .DET_WIDTH(1), .ACK_CLEAR_ONE(0)) u_dut_w1 (
    .clk(clk), .rst_n(rst_n), .bus_we(we1), .bus_addr(bus_addr[3:0]),
    .bus_wdata(bus_wdata), .bus_rdata(rdata1), .pad_in(pad_in1),
    .alt_out(2'b00), .alt_oe(2'b00), .pad_out(pad_out1), .pad_oe(pad_oe1),
    .pad_pull(pad_pull1), .pad_drive(pad_drive1), .irq_apps(irq1)
  );

  // Monitor: pops expected items and compares them mid-cycle
  always @(negedge clk) begin
    if (mon_go && exp_q.size() > 0) begin
      logic [31:0] act, e;
      int k;
      string t;
      e = exp_q.pop_front();
      k = kind_q.pop_front();
      t = tag_q.pop_front();
      case (k)
        0:       act = rdata0;
        1:       act = {31'b0, irq0};
        2:       act = rdata1;
        3:       act = {31'b0, irq1};
        4:       act = {24'b0, pad_oe0, pad_out0};
        default: act = {27'b0, pad_pull0[1:0], pad_drive0[2:0]};
      endcase
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s actual %h expected %h", t, act, e);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input int sel, input int pin, input int rg, input logic [31:0] d);
    bus_addr  = {pin[1:0], rg[2:0]};
    bus_wdata = d;
    if (sel == 0) we0 = 1'b1; else we1 = 1'b1;
    @(posedge clk); #1;
    we0 = 1'b0;
    we1 = 1'b0;
  endtask

  // Driver: pushes an expected item; the monitor compares within this cycle
  task automatic chk(input int kind, input int pin, input int rg,
                     input logic [31:0] e, input string tag);
    bus_addr = {pin[1:0], rg[2:0]};
    exp_q.push_back(e);
    kind_q.push_back(kind);
    tag_q.push_back(tag);
    mon_go = 1'b1;
    @(posedge clk); #1;
    mon_go = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; we0 = 1'b0; we1 = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in0 = '0; alt_out0 = '0; alt_oe0 = '0; pad_in1 = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc(3);

    chk(0, 0, 0, 32'h0, "R1 control reset");
    chk(0, 3, 3, 32'h0, "R1 status reset");
    chk(1, 0, 0, 32'h0, "R1 irq reset");
    chk(4, 0, 0, 32'h0, "R1 pad reset");

    wr(0, 0, 0, 32'h1F0);
    chk(0, 0, 0, 32'h1F0, "R2 control readback");
    chk(5, 0, 0, 32'h17, "R3 pull and drive codes");
    wr(0, 1, 0, 32'hFFFF_FFFF);
    chk(0, 1, 0, 32'h1FF, "R2 upper bits read zero");

    wr(0, 0, 1, 32'hFFFF_FFFF);
    chk(0, 0, 1, 32'h1, "R4 output bit, input read-only");
    chk(4, 0, 0, 32'h11, "R3 gpio mode and alt pin idle");
    alt_out0 = 4'b0010; alt_oe0 = 4'b0010;
    chk(4, 0, 0, 32'h33, "R3 alternate function routed");
    alt_out0 = 4'b0000; alt_oe0 = 4'b0000;
    chk(4, 0, 0, 32'h11, "R3 alternate ignores control oe");

    pad_in0[0] = 1'b1;
    cyc(4);
    chk(0, 0, 1, 32'h3, "R4 input visible");

    pad_in0[2] = 1'b1;
    chk(0, 2, 1, 32'h0, "R4 sync period 1");
    chk(0, 2, 1, 32'h0, "R4 sync period 2");
    chk(0, 2, 1, 32'h2, "R4 sync period 3");

    wr(0, 3, 4, 32'h4);
    wr(0, 3, 2, 32'h17);
    chk(0, 3, 2, 32'h17, "R5 config readback");
    pad_in0[3] = 1'b1;
    chk(0, 3, 3, 32'h0, "R5 latency period 1");
    chk(0, 3, 3, 32'h0, "R5 latency period 2");
    chk(0, 3, 3, 32'h0, "R5 latency period 3");
    chk(0, 3, 3, 32'h1, "R5 rising sets status");
    chk(1, 0, 0, 32'h1, "R10 summary raised");

    pad_in0[3] = 1'b0; cyc(4); pad_in0[3] = 1'b1; cyc(4);
    chk(0, 3, 3, 32'h1, "R8 edge status sticky");
    wr(0, 3, 3, 32'h1);
    chk(0, 3, 3, 32'h0, "R9 ack clears");
    chk(1, 0, 0, 32'h0, "R10 summary cleared");

    pad_in0[3] = 1'b0; cyc(4); pad_in0[3] = 1'b1; cyc(4);
    chk(0, 3, 3, 32'h1, "R5 second rising edge");
    wr(0, 3, 3, 32'h0);
    chk(0, 3, 3, 32'h1, "R9 wrong sense ignored");
    wr(0, 3, 3, 32'h1);
    chk(0, 3, 3, 32'h0, "R9 ack clears again");

    wr(0, 3, 2, 32'h1B);
    pad_in0[3] = 1'b0; cyc(4);
    chk(0, 3, 3, 32'h1, "R5 falling sets");
    wr(0, 3, 3, 32'h1);
    pad_in0[3] = 1'b1; cyc(4);
    chk(0, 3, 3, 32'h0, "R5 falling ignores rise");

    wr(0, 3, 2, 32'h1F);
    pad_in0[3] = 1'b0; cyc(4);
    chk(0, 3, 3, 32'h1, "R5 both edges on fall");
    wr(0, 3, 3, 32'h1);
    pad_in0[3] = 1'b1; cyc(4);
    chk(0, 3, 3, 32'h1, "R5 both edges on rise");
    wr(0, 3, 3, 32'h1);

    wr(0, 3, 2, 32'h13);
    cyc(2);
    chk(0, 3, 3, 32'h1, "R5 level high");
    wr(0, 3, 3, 32'h1);
    chk(0, 3, 3, 32'h1, "R8 level sets again after ack");
    pad_in0[3] = 1'b0; cyc(4);
    wr(0, 3, 3, 32'h1);
    chk(0, 3, 3, 32'h0, "R5 level inactive clears");

    wr(0, 3, 2, 32'h11);
    cyc(2);
    chk(0, 3, 3, 32'h1, "R5 level low");
    pad_in0[3] = 1'b1; cyc(4);
    wr(0, 3, 3, 32'h1);
    chk(0, 3, 3, 32'h0, "R5 level low released");

    wr(0, 2, 4, 32'h4);
    wr(0, 2, 2, 32'h07);
    pad_in0[2] = 1'b0; cyc(4); pad_in0[2] = 1'b1; cyc(4);
    chk(0, 2, 3, 32'h0, "R7 raw enable clear blocks status");
    chk(1, 0, 0, 32'h0, "R7 summary stays low");

    wr(0, 1, 4, 32'h4);
    wr(0, 1, 2, 32'h16);
    pad_in0[1] = 1'b1; cyc(4);
    chk(0, 1, 3, 32'h1, "R11 latched while disabled");
    chk(1, 0, 0, 32'h0, "R11 summary gated by enable");
    wr(0, 1, 2, 32'h17);
    chk(1, 0, 0, 32'h1, "R10 enabled pin raises summary");
    wr(0, 1, 4, 32'h3);
    chk(1, 0, 0, 32'h0, "R10 other destination");
    wr(0, 1, 4, 32'h4);
    chk(1, 0, 0, 32'h1, "R10 destination restored");
    wr(0, 1, 3, 32'h1);
    chk(1, 0, 0, 32'h0, "R10 summary after ack");

    chk(0, 0, 5, 32'h0, "R12 unmapped reads zero");
    wr(0, 0, 6, 32'hFFFF_FFFF);
    chk(0, 0, 0, 32'h1F0, "R12 unmapped write ignored");

    wr(1, 0, 2, 32'h1F);
    chk(2, 0, 2, 32'h17, "R6 upper mode bit dropped");
    wr(1, 0, 4, 32'h4);
    pad_in1[0] = 1'b1; cyc(4);
    chk(2, 0, 3, 32'h1, "R6 edge polarity 1 rising");
    chk(3, 0, 0, 32'h1, "R10 summary narrow variant");
    wr(1, 0, 3, 32'h1);
    chk(2, 0, 3, 32'h1, "R9 clear-by-zero ignores one");
    wr(1, 0, 3, 32'h0);
    chk(2, 0, 3, 32'h0, "R9 clear-by-zero clears");
    wr(1, 0, 2, 32'h15);
    pad_in1[0] = 1'b0; cyc(4);
    chk(2, 0, 3, 32'h1, "R6 edge polarity 0 falling");
    wr(1, 0, 3, 32'h0);
    pad_in1[0] = 1'b1; cyc(4);
    chk(2, 0, 3, 32'h0, "R6 falling ignores rise");
    wr(1, 0, 2, 32'h13);
    cyc(2);
    chk(2, 0, 3, 32'h1, "R6 level high");

    cyc(2);
    done = 1;
    summary();
    $finish;
  end
endmodule